// File: doc/BRIEF.md
# Link Credit Release Packet Generator

This block counts receive-buffer entries that the local side has released. It keeps one count per buffer class: posted command, posted data, non-posted command, non-posted data, response command and response data. From these counts it builds 4-byte no-operation information packets, which hand the released entries back to the link partner as flow-control credit. Each class field in a packet can carry at most three entries. Entries beyond that stay pending and go out in later packets, so none are lost. After reset every class count starts at a configurable buffer depth, so the initial credit is advertised by the first packets after reset.

The link transmitter grants a packet slot with `nop_ready_i`. A packet is offered whenever any class has pending entries or a disconnect is requested. Byte 3 of the packet echoes the receive sequence number to acknowledge. Byte 0 leaves the block in bits 7:0 of the output dword.

Top module: `fcn_nop_gen`

## Requirements
- R1: After reset, each class count holds its configured initial depth, so the first packet offered shows min(depth, 3) in every class field.
- R2: Class fields are 2 bits wide and sit at these dword positions: posted command 9:8, posted data 11:10, response command 13:12, response data 15:14, non-posted command 17:16, non-posted data 19:18.
- R3: Each field shows min(pending, 3) for its class. When a packet is accepted (`nop_valid_o` and `nop_ready_i` both high), the shown amount is subtracted from that class count.
- R4: A release pulse in the same cycle as an accepted packet is still added to the count, on top of the subtraction.
- R5: `nop_valid_o` is high exactly when some class count is nonzero or `discon_req_i` is high. An accepted packet never reports nothing.
- R6: Bits 5:0 (the no-operation command code 000000b), bit 7 and bits 23:20 are always zero. Bit 6 follows `discon_req_i`.
- R7: Bits 31:24 equal `ack_seq_i` in the same cycle.
- R8: While a packet is offered and not accepted, and no release arrives, the class fields hold their values.
- R9: Over any run, the amounts reported per class sum to the initial depth plus the number of release pulses, once all pending entries have been drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| free_i | input | 6 | One release pulse per class: bit 0 posted cmd, 1 posted data, 2 non-posted cmd, 3 non-posted data, 4 response cmd, 5 response data |
| discon_req_i | input | 1 | Disconnect sequence starting; sets bit 6 and forces a packet |
| ack_seq_i | input | 8 | Receive sequence number to acknowledge, copied into byte 3 |
| nop_ready_i | input | 1 | Packet slot granted by the link transmitter |
| nop_valid_o | output | 1 | Packet offered |
| nop_data_o | output | 32 | Packet dword, byte 0 in bits 7:0 |

## Verification
A release pulse sampled at a clock edge shows in the class fields, and in `nop_valid_o`, from that edge on. An accepted packet lowers the counts at the edge that closes the accepting cycle. `discon_req_i` and `ack_seq_i` reach the outputs in the same cycle, through logic only. The driver sets the inputs just after a rising edge and computes the expected output from its own per-class model. The monitor compares at the following falling edge, inside that same cycle, and then steps the model by the accepted amounts and the pulses.

// File: rtl/fcn_pkg.sv
package fcn_pkg;
   localparam int unsigned NUM_CLASSES = 6;
   localparam int unsigned FIELD_W     = 2;
   localparam int unsigned FIELD_MAX   = 3;

   typedef enum logic [2:0] {
      CL_PCMD  = 3'd0,
      CL_PDATA = 3'd1,
      CL_NPCMD = 3'd2,
      CL_NPDATA= 3'd3,
      CL_RCMD  = 3'd4,
      CL_RDATA = 3'd5
   } fc_class_e;

   // dword bit position of each class field (decoded by the link partner)
   function automatic int unsigned field_lsb(input int unsigned cls);
      case (cls)
         0:       return 8;
         1:       return 10;
         2:       return 16;
         3:       return 18;
         4:       return 12;
         default: return 14;
      endcase
   endfunction
endpackage

// File: rtl/fcn_credit_ctr.sv
module fcn_credit_ctr #(
   parameter int unsigned CW   = 6,
   parameter int unsigned INIT = 0,
   parameter int unsigned FMAX = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          free_i,
   input  logic          take_i,
   output logic [CW-1:0] cnt_o,
   output logic [1:0]    field_o
);
   localparam logic [CW-1:0] FMAX_V = CW'(FMAX);
   localparam logic [CW-1:0] INIT_V = CW'(INIT);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] dec;
   logic [CW-1:0] inc;

   initial begin : chk_params
      assert (CW >= 2) else $fatal(1, "counter width below 2");
      assert (INIT < (1 << CW)) else $fatal(1, "initial depth exceeds counter");
      assert (FMAX == 3) else $fatal(1, "field limit must be 3");
   end

   assign field_o = (cnt_q >= FMAX_V) ? 2'(FMAX) : cnt_q[1:0];
   assign dec     = take_i ? {{(CW-2){1'b0}}, field_o} : '0;
   assign inc     = {{(CW-1){1'b0}}, free_i};
   assign cnt_o   = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= INIT_V;
      else        cnt_q <= cnt_q - dec + inc;
   end
endmodule

// File: rtl/fcn_packer.sv
module fcn_packer
   import fcn_pkg::*;
#(
   parameter int unsigned NC = NUM_CLASSES
) (
   input  logic [NC*FIELD_W-1:0] fields_i,
   input  logic                  discon_i,
   input  logic [7:0]            ack_i,
   output logic [31:0]           dword_o
);
   initial begin : chk_params
      assert (NC == 6) else $fatal(1, "packet layout holds six classes");
   end

   always_comb begin
      dword_o        = '0;
      dword_o[6]     = discon_i;
      for (int unsigned c = 0; c < NC; c++) begin
         dword_o[field_lsb(c) +: FIELD_W] = fields_i[c*FIELD_W +: FIELD_W];
      end
      dword_o[31:24] = ack_i;
   end
endmodule

// File: rtl/fcn_nop_gen.sv
module fcn_nop_gen
   import fcn_pkg::*;
#(
   parameter int unsigned CNT_W = 6,
   parameter int unsigned INIT_DEPTH [NUM_CLASSES] = '{4, 2, 4, 2, 8, 4}
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [5:0]  free_i,
   input  logic        discon_req_i,
   input  logic [7:0]  ack_seq_i,
   input  logic        nop_ready_i,
   output logic        nop_valid_o,
   output logic [31:0] nop_data_o
);
   localparam int unsigned FLAT_W = NUM_CLASSES * FIELD_W;

   logic [FLAT_W-1:0]            field_flat;
   logic [NUM_CLASSES*CNT_W-1:0] pend_flat;
   logic                         fire;

   initial begin : chk_params
      assert (CNT_W >= 6) else $fatal(1, "pending counter narrower than 6 bits");
   end

   assign nop_valid_o = (|field_flat) | discon_req_i;
   assign fire        = nop_valid_o & nop_ready_i;

   for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
      fcn_credit_ctr #(
         .CW   (CNT_W),
         .INIT (INIT_DEPTH[c]),
         .FMAX (FIELD_MAX)
      ) u_ctr (
         .clk     (clk),
         .rst_n   (rst_n),
         .free_i  (free_i[c]),
         .take_i  (fire),
         .cnt_o   (pend_flat[c*CNT_W +: CNT_W]),
         .field_o (field_flat[c*FIELD_W +: FIELD_W])
      );
   end

   fcn_packer #(.NC(NUM_CLASSES)) u_pack (
      .fields_i (field_flat),
      .discon_i (discon_req_i),
      .ack_i    (ack_seq_i),
      .dword_o  (nop_data_o)
   );
endmodule

// File: rtl/fcn_nop_chk.sv
module fcn_nop_chk #(
   parameter int unsigned NC = 6,
   parameter int unsigned CW = 6
) (
   input logic           clk,
   input logic           rst_n,
   input logic [NC-1:0]  free_i,
   input logic           discon_req_i,
   input logic [7:0]     ack_seq_i,
   input logic           nop_ready_i,
   input logic           nop_valid_o,
   input logic [31:0]    nop_data_o,
   input logic [NC*CW-1:0] pend_flat
);
   localparam logic [CW-1:0] CMAX = '1;

   assert_fixed_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      nop_valid_o |-> (nop_data_o[5:0] == 6'd0 && !nop_data_o[7] && nop_data_o[23:20] == 4'd0));

   assert_ack_echo_R7: assert property (@(posedge clk) disable iff (!rst_n)
      nop_valid_o |-> (nop_data_o[31:24] == ack_seq_i));

   assert_no_empty_nop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (nop_valid_o && nop_ready_i) |-> (nop_data_o[19:8] != 12'd0 || nop_data_o[6]));

   assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (nop_valid_o && !nop_ready_i && free_i == '0) |=> $stable(nop_data_o[19:8]));

   assert_drain_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (nop_valid_o && nop_ready_i && nop_data_o[9:8] != 2'd3 && !free_i[0])
      |=> (nop_data_o[9:8] == 2'd0));

   for (genvar c = 0; c < NC; c++) begin : g_ovf
      assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (pend_flat[c*CW +: CW] == CMAX && free_i[c]) |-> (nop_valid_o && nop_ready_i));
   end
endmodule

bind fcn_nop_gen fcn_nop_chk #(.NC(fcn_pkg::NUM_CLASSES), .CW(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .free_i       (free_i),
   .discon_req_i (discon_req_i),
   .ack_seq_i    (ack_seq_i),
   .nop_ready_i  (nop_ready_i),
   .nop_valid_o  (nop_valid_o),
   .nop_data_o   (nop_data_o),
   .pend_flat    (pend_flat)
);

// File: tb/sim_fcn_nop_gen.sv
module sim_fcn_nop_gen;
   localparam int unsigned INIT [6] = '{5, 1, 0, 2, 4, 7};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  free_i = '0;
   logic        discon_req_i = 1'b0;
   logic [7:0]  ack_seq_i = '0;
   logic        nop_ready_i = 1'b0;
   logic        nop_valid_o;
   logic [31:0] nop_data_o;

   int errors = 0;
   int checks = 0;

   always #5 clk = ~clk;

   fcn_nop_gen #(.CNT_W(6), .INIT_DEPTH(INIT)) u0 (
      .clk(clk), .rst_n(rst_n), .free_i(free_i), .discon_req_i(discon_req_i),
      .ack_seq_i(ack_seq_i), .nop_ready_i(nop_ready_i),
      .nop_valid_o(nop_valid_o), .nop_data_o(nop_data_o)
   );

   typedef struct {
      logic        v;
      logic        rdy;
      logic [31:0] d;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   pend [6];
   int   freed [6];
   int   reported [6];

   function automatic int lsb_of(input int c);
      case (c)
         0: return 8;  1: return 10; 2: return 16;
         3: return 18; 4: return 12; default: return 14;
      endcase
   endfunction

   function automatic int fmin3(input int x);
      return (x > 3) ? 3 : x;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // driver: set inputs, push expected output, step the model
   task automatic step(input logic [5:0] fr, input logic dc, input logic rd,
                       input logic [7:0] ak, input string tag);
      exp_t e;
      int any;
      @(posedge clk);
      #1;
      free_i = fr; discon_req_i = dc; nop_ready_i = rd; ack_seq_i = ak;
      any = 0;
      e.d = '0;
      for (int c = 0; c < 6; c++) begin
         e.d[lsb_of(c) +: 2] = 2'(fmin3(pend[c]));
         if (pend[c] != 0) any = 1;
      end
      e.d[6] = dc;
      e.d[31:24] = ak;
      e.v = (any != 0) || dc;
      e.rdy = rd;
      e.tag = tag;
      q.push_back(e);
      for (int c = 0; c < 6; c++) begin
         if (e.v && rd) pend[c] -= fmin3(pend[c]);
         pend[c] += int'(fr[c]);
         freed[c] += int'(fr[c]);
      end
   endtask

   // monitor: pop and compare mid-cycle
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         check({e.tag, " valid"}, {31'd0, nop_valid_o}, {31'd0, e.v});
         if (e.v) check({e.tag, " data"}, nop_data_o, e.d);
         if (nop_valid_o && nop_ready_i)
            for (int c = 0; c < 6; c++) reported[c] += int'(nop_data_o[lsb_of(c) +: 2]);
      end
   end

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
   end

   logic [15:0] lfsr = 16'hACE1;

   initial begin : main
      for (int c = 0; c < 6; c++) begin
         pend[c] = int'(INIT[c]); freed[c] = 0; reported[c] = 0;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state, R8 hold while stalled
      step(6'd0, 1'b0, 1'b0, 8'h11, "R1");
      repeat (3) step(6'd0, 1'b0, 1'b0, 8'h11, "R8");

      // R3 drain initial credits
      for (int i = 0; i < 8; i++) step(6'd0, 1'b0, 1'b1, 8'(i), "R3");
      // R5 idle: nothing offered
      repeat (2) step(6'd0, 1'b0, 1'b1, 8'h5A, "R5");

      // R6 disconnect with nothing pending
      step(6'd0, 1'b1, 1'b0, 8'hC3, "R6");
      step(6'd0, 1'b1, 1'b1, 8'h3C, "R6");

      // R2 field placement per class, R7 ack echo
      for (int c = 0; c < 6; c++) begin
         step(6'(1 << c), 1'b0, 1'b0, 8'(8'hA0 + c), "R2");
         step(6'd0, 1'b0, 1'b1, 8'(8'hB0 + c), "R7");
      end

      // R4 release during accept
      repeat (3) step(6'b000100, 1'b0, 1'b0, 8'h01, "R4");
      step(6'b000100, 1'b0, 1'b1, 8'h02, "R4");
      step(6'd0, 1'b0, 1'b0, 8'h03, "R4");
      step(6'b000100, 1'b0, 1'b1, 8'h04, "R4");
      step(6'd0, 1'b0, 1'b0, 8'h05, "R4");

      // R8 burst with stall, then drain
      repeat (10) step(6'b100000, 1'b0, 1'b0, 8'h77, "R8");
      for (int i = 0; i < 10; i++) step(6'd0, 1'b0, 1'b1, 8'h78, "R3");

      // mixed traffic
      for (int i = 0; i < 300; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr[5:0] & lfsr[11:6], lfsr[15] & lfsr[14] & lfsr[13],
              lfsr[12] | lfsr[13], lfsr[7:0], "R3");
      end
      for (int i = 0; i < 40; i++) step(6'd0, 1'b0, 1'b1, 8'hEE, "R3");
      step(6'd0, 1'b0, 1'b1, 8'hEF, "R5");
      @(posedge clk);
      @(negedge clk);
      #1;

      // R9 conservation per class
      for (int c = 0; c < 6; c++)
         check("R9 total", 32'(reported[c]), 32'(int'(INIT[c]) + freed[c]));

      summary();
      $finish;
   end
endmodule